// File: doc/BRIEF.md
# Tiled Operand Address Generator

This block produces the byte address of one tiled operand, such as a fill pattern or a copy source, while a two-dimensional rectangle operation walks its destination. The operand repeats as a tile. Its width and its height are each chosen by a separate 3-bit code, and each axis wraps on its own. The block keeps three values: a horizontal index inside the tile, a vertical index inside the tile, and the address of the current tile row. The address it presents is always the row address plus the horizontal index.

A sequencer outside the block loads a start address, a row pitch and the two wrap codes with one strobe. After that it issues horizontal steps, vertical steps and new-line requests as the operation moves across the rectangle. The block does not read memory, does not compute raster results, and does not contain the register bus that holds the parameters.

Top module: `tile_addr_gen`

## Requirements
- R1: After reset, `addr` is 0.
- R2: While `load` is high, the block samples `startAddr`, `rowOff`, `xCode` and `yCode`. On the next cycle `addr` equals the sampled start address. `load` takes priority over every step and new-line input in the same cycle.
- R3: `xCode` sets the horizontal index mask as follows: 0→0, 1→0, 2→3, 3→7, 4→15, 5→31, 6→63. Code 7 means the horizontal index is unlimited (mask of all ones). The tile width is the mask plus 1. At load, the horizontal index starts as `startAddr & mask`, and the row address starts as `startAddr` minus that index.
- R4: A forward horizontal step (`stepX`=1, `xDown`=0) adds 1 to the horizontal index. When the result reaches the tile width, it returns to 0.
- R5: A backward horizontal step (`stepX`=1, `xDown`=1) subtracts 1 from the horizontal index. When the result goes below 0, it becomes the mask.
- R6: When `yCode[2]` is 0, the tile height is 2^`yCode[1:0]` (1, 2, 4 or 8). When `yCode[2]` is 1, vertical wrap is off and the vertical index runs freely. With a finite width and vertical wrap on, the vertical index starts at (`startAddr` / width) mod height.
- R7: A forward vertical step (`stepY`=1, `yDown`=0) adds `rowOff`+1 to the row address and 1 to the vertical index. If the vertical index was height−1 and vertical wrap is on, the vertical index becomes 0 and the row address is reloaded from the tile base instead.
- R8: A backward vertical step (`stepY`=1, `yDown`=1) subtracts `rowOff`+1 from the row address and 1 from the vertical index. If the vertical index was 0 and vertical wrap is on, the vertical index becomes height−1 and the row address becomes base + mask×(height−1) instead.
- R9: The tile base is `startAddr` with its low bits cleared. The cleared bits are (w×h)−1, where w is the tile width (1 when the width is unlimited) and h is the tile height (1 when vertical wrap is off).
- R10: `newLine` restores the horizontal index to its value at load, and it overrides `stepX` in the same cycle. Vertical steps in the same cycle still apply.
- R11: All address arithmetic is modulo 2^`ADDR_W`.
- R12: In a cycle with no load, no step and no new-line request, `addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| load | input | 1 | Load strobe for the operation parameters |
| startAddr | input | ADDR_W | Start address of the operand |
| rowOff | input | OFF_W | Row pitch minus one |
| xCode | input | 3 | Horizontal wrap code |
| yCode | input | 3 | Vertical wrap code; bit 2 disables vertical wrap |
| newLine | input | 1 | Restore the horizontal index to its start value |
| stepX | input | 1 | Horizontal step request |
| xDown | input | 1 | Direction of the horizontal step; 1 means backward |
| stepY | input | 1 | Vertical step request |
| yDown | input | 1 | Direction of the vertical step; 1 means backward |
| addr | output | ADDR_W | Current operand address |

## Verification
The bench targets the following corner cases:
- **Backward vertical wrap.** The reload value is mask×(height−1), not width×(height−1). A design that used the width would land one byte per row too far.
- **Tile base clearing.** A start address that sits in the middle of a tile must have its low bits cleared. A design that skipped this would reload to the unaligned start on a forward vertical wrap.
- **Edge codes.** Horizontal codes 0 and 1 must keep the index at 0. Code 7 must run the index freely across the top of the address space and wrap modulo 2^`ADDR_W`. A vertical code with bit 2 set must never reload the row.
- **Input priorities.** The bench exercises `load` against steps and `newLine` against `stepX`. A wrong ordering shows up as an address one step off from the expected value.

// File: rtl/tile_addr_pkg.sv
`timescale 1ns/1ps
package tile_addr_pkg;

  // Strobes from control to datapath, at most one X action per cycle
  typedef struct packed {
    logic load;
    logic restoreX;
    logic incX;
    logic decX;
    logic incY;
    logic decY;
  } stepCmd_t;

  typedef struct packed {
    logic [2:0] xLog;   // log2 of tile width when finite
    logic       xUnl;   // unlimited width
    logic [1:0] yLog;   // log2 of tile height
    logic       yWrap;  // vertical wrap enabled
  } wrapCfg_t;

  function automatic wrapCfg_t decodeWrap(input logic [2:0] xc, input logic [2:0] yc);
    wrapCfg_t c;
    c.xUnl  = (xc == 3'd7);
    c.xLog  = (xc < 3'd2 || xc == 3'd7) ? 3'd0 : xc;
    c.yWrap = !yc[2];
    c.yLog  = yc[1:0];
    return c;
  endfunction

endpackage

// File: rtl/tile_addr_ctrl.sv
`timescale 1ns/1ps
module tile_addr_ctrl
  import tile_addr_pkg::*;
(
  input  logic     load,
  input  logic     newLine,
  input  logic     stepX,
  input  logic     xDown,
  input  logic     stepY,
  input  logic     yDown,
  output stepCmd_t cmd
);

  logic xFree;
  logic yFree;

  always_comb begin
    xFree = !load && !newLine && stepX;
    yFree = !load && stepY;
    cmd.load     = load;
    cmd.restoreX = !load && newLine;
    cmd.incX     = xFree && !xDown;
    cmd.decX     = xFree && xDown;
    cmd.incY     = yFree && !yDown;
    cmd.decY     = yFree && yDown;
  end

endmodule

// File: rtl/tile_addr_dp.sv
`timescale 1ns/1ps
module tile_addr_dp
  import tile_addr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCmd_t          cmd,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [OFF_W-1:0]  rowOff,
  input  logic [2:0]        xCode,
  input  logic [2:0]        yCode,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] xIdx,
  output logic [ADDR_W-1:0] xStart,
  output logic [ADDR_W-1:0] xMask,
  output logic [2:0]        yIdx,
  output logic              yWrap,
  output logic [2:0]        heightM1
);

  localparam int TB_W = 4;

  function automatic logic [ADDR_W-1:0] maskOf(input wrapCfg_t c);
    return c.xUnl ? '1 : ADDR_W'((1 << c.xLog) - 1);
  endfunction

  function automatic logic [2:0] hm1Of(input wrapCfg_t c);
    return c.yWrap ? 3'((1 << c.yLog) - 1) : 3'd0;
  endfunction

  wrapCfg_t          cfgQ, cfgIn;
  logic [OFF_W-1:0]  offQ;
  logic [ADDR_W-1:0] baseQ, rowQ, xQ, xStartQ;
  logic [2:0]        yQ;

  logic [ADDR_W-1:0] mIn, baseIn, xIn, rowIn, shiftIn;
  logic [2:0]        hIn, yIn;
  logic [TB_W-1:0]   tileBits;
  logic [ADDR_W-1:0] mQ, stepAmt, lastRow;
  logic [2:0]        hQ;

  // values captured at load
  always_comb begin
    cfgIn    = decodeWrap(xCode, yCode);
    mIn      = maskOf(cfgIn);
    hIn      = hm1Of(cfgIn);
    tileBits = (cfgIn.xUnl ? 4'd0 : {1'b0, cfgIn.xLog})
             + (cfgIn.yWrap ? {2'b00, cfgIn.yLog} : 4'd0);
    baseIn   = startAddr & ~ADDR_W'((1 << tileBits) - 1);
    xIn      = startAddr & mIn;
    rowIn    = startAddr - xIn;
    shiftIn  = startAddr >> cfgIn.xLog;
    yIn      = (cfgIn.yWrap && !cfgIn.xUnl) ? (shiftIn[2:0] & hIn) : 3'd0;
  end

  // values used while stepping
  always_comb begin
    mQ      = maskOf(cfgQ);
    hQ      = hm1Of(cfgQ);
    stepAmt = ADDR_W'(offQ) + ADDR_W'(1);
    lastRow = baseQ + ((mQ << cfgQ.yLog) - mQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ    <= '0;
      offQ    <= '0;
      baseQ   <= '0;
      rowQ    <= '0;
      xQ      <= '0;
      xStartQ <= '0;
      yQ      <= '0;
    end else if (cmd.load) begin
      cfgQ    <= cfgIn;
      offQ    <= rowOff;
      baseQ   <= baseIn;
      rowQ    <= rowIn;
      xQ      <= xIn;
      xStartQ <= xIn;
      yQ      <= yIn;
    end else begin
      if (cmd.restoreX)  xQ <= xStartQ;
      else if (cmd.incX) xQ <= (xQ + ADDR_W'(1)) & mQ;
      else if (cmd.decX) xQ <= (xQ - ADDR_W'(1)) & mQ;

      if (cmd.incY) begin
        if (cfgQ.yWrap && yQ == hQ) begin
          yQ   <= 3'd0;
          rowQ <= baseQ;
        end else begin
          yQ   <= yQ + 3'd1;
          rowQ <= rowQ + stepAmt;
        end
      end else if (cmd.decY) begin
        if (cfgQ.yWrap && yQ == 3'd0) begin
          yQ   <= hQ;
          rowQ <= lastRow;
        end else begin
          yQ   <= yQ - 3'd1;
          rowQ <= rowQ - stepAmt;
        end
      end
    end
  end

  assign addr     = rowQ + xQ;
  assign xIdx     = xQ;
  assign xStart   = xStartQ;
  assign xMask    = mQ;
  assign yIdx     = yQ;
  assign yWrap    = cfgQ.yWrap;
  assign heightM1 = hQ;

endmodule

// File: rtl/tile_addr_gen.sv
`timescale 1ns/1ps
module tile_addr_gen
  import tile_addr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [OFF_W-1:0]  rowOff,
  input  logic [2:0]        xCode,
  input  logic [2:0]        yCode,
  input  logic              newLine,
  input  logic              stepX,
  input  logic              xDown,
  input  logic              stepY,
  input  logic              yDown,
  output logic [ADDR_W-1:0] addr
);

  stepCmd_t          cmd;
  logic [ADDR_W-1:0] xIdx, xStart, xMask;
  logic [2:0]        yIdx, heightM1;
  logic              yWrap;

  tile_addr_ctrl u_ctrl (
    .load(load), .newLine(newLine), .stepX(stepX), .xDown(xDown),
    .stepY(stepY), .yDown(yDown), .cmd(cmd)
  );

  tile_addr_dp #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .startAddr(startAddr),
    .rowOff(rowOff), .xCode(xCode), .yCode(yCode), .addr(addr),
    .xIdx(xIdx), .xStart(xStart), .xMask(xMask), .yIdx(yIdx),
    .yWrap(yWrap), .heightM1(heightM1)
  );

endmodule

// File: rtl/tile_addr_chk.sv
`timescale 1ns/1ps
module tile_addr_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              load,
  input logic              newLine,
  input logic              stepX,
  input logic              stepY,
  input logic [ADDR_W-1:0] startAddr,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] xIdx,
  input logic [ADDR_W-1:0] xStart,
  input logic [ADDR_W-1:0] xMask,
  input logic [2:0]        yIdx,
  input logic              yWrap,
  input logic [2:0]        heightM1
);

  p_load_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    load |=> addr == $past(startAddr));

  p_x_in_tile_r3: assert property (@(posedge clk) disable iff (!rstN)
    (xIdx & ~xMask) == '0);

  p_y_in_tile_r6: assert property (@(posedge clk) disable iff (!rstN)
    yWrap |-> yIdx <= heightM1);

  p_restore_x_r10: assert property (@(posedge clk) disable iff (!rstN)
    (newLine && !load) |=> xIdx == $past(xStart));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !newLine && !stepX && !stepY) |=> $stable(addr));

endmodule

bind tile_addr_gen tile_addr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .load(load), .newLine(newLine), .stepX(stepX),
  .stepY(stepY), .startAddr(startAddr), .addr(addr), .xIdx(xIdx),
  .xStart(xStart), .xMask(xMask), .yIdx(yIdx), .yWrap(yWrap),
  .heightM1(heightM1)
);

// File: tb/tile_addr_gen_bench.sv
`timescale 1ns/1ps
module tile_addr_gen_bench;
  localparam int ADDR_W = 24;
  localparam int OFF_W  = 16;
  localparam longint AM = (64'd1 << ADDR_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic load = 1'b0, newLine = 1'b0, stepX = 1'b0, xDown = 1'b0, stepY = 1'b0, yDown = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [OFF_W-1:0]  rowOff = '0;
  logic [2:0] xCode = '0, yCode = '0;
  logic [ADDR_W-1:0] addr;

  always #10 clk = ~clk;

  tile_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_tile_addr_gen (
    .clk(clk), .rstN(rstN), .load(load), .startAddr(startAddr), .rowOff(rowOff),
    .xCode(xCode), .yCode(yCode), .newLine(newLine), .stepX(stepX), .xDown(xDown),
    .stepY(stepY), .yDown(yDown), .addr(addr)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string curTag = "R1";

  // reference state
  longint mBase = 0, mRow = 0, mX = 0, mXs = 0, mY = 0, mOff = 0, mMask = 0, mH = 1;
  bit mYw = 0;

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic compare();
    longint exp;
    exp = (mRow + mX) & AM;
    checks++;
    if (longint'(addr) != exp) begin
      errors++;
      $display("FAIL %s addr actual %h expected %h", curTag, addr, exp[ADDR_W-1:0]);
    end
  endtask

  task automatic modelLoad(input longint st, input longint off, input int xc, input int yc);
    longint w;
    bit unl;
    case (xc)
      0, 1: mMask = 0;
      2: mMask = 3;
      3: mMask = 7;
      4: mMask = 15;
      5: mMask = 31;
      6: mMask = 63;
      default: mMask = AM;
    endcase
    unl  = (xc == 7);
    mYw  = ((yc & 4) == 0);
    mH   = mYw ? (64'd1 << (yc & 3)) : 1;
    w    = unl ? 1 : mMask + 1;
    mBase = st & ~((w * mH) - 1) & AM;
    mX   = st & mMask;
    mXs  = mX;
    mRow = (st - mX) & AM;
    mY   = (mYw && !unl) ? ((st / w) % mH) : 0;
    mOff = off;
  endtask

  // one cycle: check previous result, drive new inputs, advance the model
  task automatic cyc(input bit ld, input longint st, input longint off, input int xc, input int yc,
                     input bit nl, input bit sx, input bit xd, input bit sy, input bit yd,
                     input string tag);
    @(negedge clk);
    compare();
    load = ld; startAddr = st[ADDR_W-1:0]; rowOff = off[OFF_W-1:0];
    xCode = 3'(xc); yCode = 3'(yc);
    newLine = nl; stepX = sx; xDown = xd; stepY = sy; yDown = yd;
    if (ld) modelLoad(st, off, xc, yc);
    else begin
      if (nl) mX = mXs;
      else if (sx) mX = (xd ? mX - 1 : mX + 1) & mMask;
      if (sy && !yd) begin
        if (mYw && mY == mH - 1) begin mY = 0; mRow = mBase; end
        else begin mY = (mY + 1) & 7; mRow = (mRow + mOff + 1) & AM; end
      end else if (sy && yd) begin
        if (mYw && mY == 0) begin mY = mH - 1; mRow = (mBase + mMask * (mH - 1)) & AM; end
        else begin mY = (mY - 1) & 7; mRow = (mRow - mOff - 1) & AM; end
      end
    end
    curTag = tag;
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    curTag = "R1";
    idle("R12");

    // R2: load with steps also asserted, load wins
    cyc(1, 24'h001234, 15, 3, 1, 1, 1, 0, 1, 0, "R2");
    idle("R12");
    // R4: forward X wrap inside width 8
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R4");
    // R5: backward X wrap
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R5");
    // R7 / R8: vertical both ways, height 2
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R7");
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R8");
    // R10: new line overrides stepX, with a vertical step
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, 0, 1, 1, 0, 1, 0, "R10");
    idle("R10");

    // R3: codes 0,1 keep X at 0; code 5 width 32
    cyc(1, 24'h000abc, 3, 0, 4, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R3");
    cyc(1, 24'h000abc, 3, 1, 4, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R3");
    cyc(1, 24'h004321, 63, 5, 4, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 40; i++) cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R3");

    // R9: mid-tile start, width 4 height 2
    cyc(1, 24'h012345, 3, 2, 1, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R9");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R9");

    // R6: height 8 then vertical wrap disabled
    cyc(1, 24'h0007f5, 7, 3, 3, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 12; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R6");
    for (int i = 0; i < 12; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R6");
    cyc(1, 24'h0007f5, 7, 3, 7, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 12; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R6");

    // R11: unlimited X across the top of the address space
    cyc(1, 24'hfffffe, 0, 7, 4, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R11");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R11");
    cyc(1, 24'h000010, 16'hffff, 7, 4, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R11");

    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit ld, nl, sx, xd, sy, yd;
      string t;
      r  = $urandom_range(0, 39);
      ld = (r == 0);
      nl = ($urandom_range(0, 9) == 0);
      sx = $urandom_range(0, 1);
      xd = $urandom_range(0, 1);
      sy = ($urandom_range(0, 3) == 0);
      yd = $urandom_range(0, 1);
      if (ld) t = "R2";
      else if (sy) t = yd ? "R8" : "R7";
      else if (nl) t = "R10";
      else if (sx) t = xd ? "R5" : "R4";
      else t = "R12";
      cyc(ld, longint'($urandom) & AM, longint'($urandom_range(0, 70)),
          $urandom_range(0, 7), $urandom_range(0, 7), nl, sx, xd, sy, yd, t);
    end
    idle("R12");
    idle("R12");
    finishRun();
  end

endmodule